// File: doc/BRIEF.md
# Dual-Rate Serial Voice Port

This block is the serial edge of one full-duplex voice channel. It has two serial sides. The PCM side carries 8-bit companded samples. The ADPCM side carries 4-bit codes. Each side has its own bit clock, its own transmit frame sync and its own receive frame sync, so the two sides run at unrelated rates. On either side, a receive sync starts the capture of one serial word. A transmit sync starts the shifting out of one word, and the line is released as soon as the last bit has been sent. The open-drain line is modelled as a data bit plus an output enable.

In normal operation the transcoding arithmetic sits outside this block. It is reached through parallel sample ports. A captured PCM sample is handed to the encoder together with a valid pulse, and the encoder's 4-bit code is serialised on the ADPCM side. In the other direction, a captured code is handed to the decoder, and the decoder's sample is serialised on the PCM side. When the pass-through control is 1, the arithmetic is bypassed. Whole 8-bit words then cross between the two sides unchanged, and the ADPCM line carries 8 bits per frame. The crossing between the clock domains uses a held source register, a destination register and a toggle handshake. A channel-enable input of 0 powers the channel down.

Top module: `voice_port`

## Requirements
- R1: When `pcm_sync_tx` is sampled high on a rising `pcm_bclk` edge k, `pcm_sdo_en` is 1 after edges k+1 to k+8 and 0 after edge k+9. Outside pass-through mode, `pcm_sdo` carries `pcm_tx_sample`, bit 7 first.
- R2: Outside pass-through mode, a sync on `adp_sync_tx` sampled at rising edge k gives exactly 4 enabled bits after edges k+1 to k+4, then release after edge k+5. The bits are `adp_tx_code`, bit 3 first.
- R3: In pass-through mode, the ADPCM transmit burst is 8 enabled bits long, followed by release.
- R4: A `pcm_sync_rx` sampled high on a falling edge causes the next 8 falling edges to capture `pcm_sdi`, bit 7 first. The word appears on `pcm_rx_sample`, and `pcm_rx_valid` pulses for one cycle, starting at the falling edge that takes the last bit.
- R5: Outside pass-through mode, an `adp_sync_rx` frame captures 4 bits, first bit as bit 3, onto `adp_rx_code`, with a one-cycle `adp_rx_valid` pulse.
- R6: In pass-through mode, the 8-bit word last received on the PCM input appears unmodified on the ADPCM output in any ADPCM transmit frame whose sync comes at least 8 `adp_bclk` cycles after reception.
- R7: In pass-through mode, the 8-bit word last received on the ADPCM input appears unmodified on the PCM output in any PCM transmit frame whose sync comes at least 8 `pcm_bclk` cycles after reception.
- R8: In pass-through mode, `pcm_rx_valid` and `adp_rx_valid` stay 0.
- R9: While `chan_en` is 0, both output enables stay 0, both valid outputs stay 0, and syncs are ignored. Normal operation resumes when `chan_en` returns to 1.
- R10: After reset, both output enables and both valid outputs are 0, and `pcm_rx_sample` is 0.
- R11: With no new word received in pass-through mode, every consuming frame repeats the last transferred word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| chan_en | input | 1 | 1 = channel running, 0 = powered down |
| passthru | input | 1 | 1 = bypass transcoding and swap 8-bit words between the sides |
| pcm_bclk | input | 1 | PCM side bit clock |
| pcm_sync_tx | input | 1 | PCM transmit frame sync |
| pcm_sync_rx | input | 1 | PCM receive frame sync |
| pcm_sdi | input | 1 | PCM serial data in |
| pcm_sdo | output | 1 | PCM serial data out |
| pcm_sdo_en | output | 1 | PCM output enable (0 = high impedance) |
| pcm_tx_sample | input | PCM_W | Decoded sample to send on the PCM line |
| pcm_rx_sample | output | PCM_W | Sample captured from the PCM line |
| pcm_rx_valid | output | 1 | One-cycle pulse when pcm_rx_sample is new |
| adp_bclk | input | 1 | ADPCM side bit clock |
| adp_sync_tx | input | 1 | ADPCM transmit frame sync |
| adp_sync_rx | input | 1 | ADPCM receive frame sync |
| adp_sdi | input | 1 | ADPCM serial data in |
| adp_sdo | output | 1 | ADPCM serial data out |
| adp_sdo_en | output | 1 | ADPCM output enable (0 = high impedance) |
| adp_tx_code | input | ADP_W | Encoded code to send on the ADPCM line |
| adp_rx_code | output | ADP_W | Code captured from the ADPCM line |
| adp_rx_valid | output | 1 | One-cycle pulse when adp_rx_code is new |

## Verification
The assertions take for granted that a new transmit sync never arrives while a burst is still in flight, and that `passthru` and `chan_en` change only while both sides are idle. The cross-domain overrun check also assumes that pass-through words arrive no faster than the handshake can return, which is a few cycles of each clock. The stimulus keeps to these conditions. It runs every frame to completion, waits a dozen cycles of the consuming clock after each pass-through word, and changes the mode only between frames. Randomised words and codes are mixed with directed all-zero, all-one and single-bit patterns. The two clocks run at unrelated periods.

// File: rtl/vp_pkg.sv
package vp_pkg;
  localparam int unsigned PCM_BITS    = 8;
  localparam int unsigned ADP_BITS    = 4;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/vp_sync2.sv
module vp_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/vp_ser_tx.sv
module vp_ser_tx #(
  parameter int unsigned MAXW = 8,
  parameter int unsigned CW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            start,
  input  logic [CW-1:0]   len,
  input  logic [MAXW-1:0] word,
  output logic            sdo,
  output logic            oe
);
  logic [MAXW-1:0] shreg;
  logic [CW-1:0]   left;

  // Launch: word is MSB aligned, one bit per rising edge after the sync edge.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      shreg <= '0;
      left  <= '0;
      sdo   <= 1'b0;
      oe    <= 1'b0;
    end else if (start) begin
      shreg <= word;
      left  <= len;
      sdo   <= 1'b0;
      oe    <= 1'b0;
    end else if (left != '0) begin
      sdo   <= shreg[MAXW-1];
      shreg <= shreg << 1;
      left  <= left - CW'(1);
      oe    <= 1'b1;
    end else begin
      sdo <= 1'b0;
      oe  <= 1'b0;
    end
  end

  // Checker state: burst length requested and enabled bits counted.
  logic [CW-1:0] len_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      run_q <= '0;
    end else begin
      if (start) len_q <= len;
      run_q <= oe ? run_q + CW'(1) : '0;
    end
  end

  // R1 R2 R3: every burst is exactly the requested number of bits long.
  a_r1_burst_len: assert property (@(posedge clk) disable iff (rst || !en)
    $fell(oe) |-> (run_q == len_q));
endmodule

// File: rtl/vp_ser_rx.sv
module vp_ser_rx #(
  parameter int unsigned MAXW = 8,
  parameter int unsigned CW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            report,
  input  logic            start,
  input  logic [CW-1:0]   len,
  input  logic            sdi,
  output logic [MAXW-1:0] word,
  output logic            done,
  output logic            valid
);
  logic [CW-1:0] left;

  // Capture on falling edges, first bit ends up as the MSB of the word.
  always_ff @(negedge clk) begin
    if (rst) begin
      word  <= '0;
      left  <= '0;
      done  <= 1'b0;
      valid <= 1'b0;
    end else if (!en) begin
      left  <= '0;
      done  <= 1'b0;
      valid <= 1'b0;
    end else begin
      done  <= 1'b0;
      valid <= 1'b0;
      if (left != '0) begin
        word <= {word[MAXW-2:0], sdi};
        left <= left - CW'(1);
        if (left == CW'(1)) begin
          done  <= 1'b1;
          valid <= report;
        end
      end else if (start) begin
        left <= len;
      end
    end
  end

  // R4 R5: completion is a single-cycle pulse.
  a_r4_single_pulse: assert property (@(negedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/vp_word_cdc.sv
module vp_word_cdc #(
  parameter int unsigned W = 8
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] hold;
  logic         tog;
  logic         ack_m, ack_s;
  logic         t_m, t_s, seen;

  // Source side: hold register plus request toggle.
  always_ff @(posedge src_clk) begin
    if (rst) begin
      hold  <= '0;
      tog   <= 1'b0;
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= seen;
      ack_s <= ack_m;
      if (load) begin
        hold <= din;
        tog  <= ~tog;
      end
    end
  end

  // Destination side: second buffer, updated once per toggle change.
  always_ff @(posedge dst_clk) begin
    if (rst) begin
      t_m  <= 1'b0;
      t_s  <= 1'b0;
      seen <= 1'b0;
      dout <= '0;
    end else begin
      t_m  <= tog;
      t_s  <= t_m;
      seen <= t_s;
      if (t_s != seen) dout <= hold;
    end
  end

  // R6 R7: a new word is never loaded before the previous one was taken.
  a_r6_no_overrun: assert property (@(posedge src_clk) disable iff (rst)
    load |-> (tog == ack_s));
endmodule

// File: rtl/voice_port.sv
module voice_port #(
  parameter int unsigned PCM_W = vp_pkg::PCM_BITS,
  parameter int unsigned ADP_W = vp_pkg::ADP_BITS
) (
  input  logic             rst,
  input  logic             chan_en,
  input  logic             passthru,
  input  logic             pcm_bclk,
  input  logic             pcm_sync_tx,
  input  logic             pcm_sync_rx,
  input  logic             pcm_sdi,
  output logic             pcm_sdo,
  output logic             pcm_sdo_en,
  input  logic [PCM_W-1:0] pcm_tx_sample,
  output logic [PCM_W-1:0] pcm_rx_sample,
  output logic             pcm_rx_valid,
  input  logic             adp_bclk,
  input  logic             adp_sync_tx,
  input  logic             adp_sync_rx,
  input  logic             adp_sdi,
  output logic             adp_sdo,
  output logic             adp_sdo_en,
  input  logic [ADP_W-1:0] adp_tx_code,
  output logic [ADP_W-1:0] adp_rx_code,
  output logic             adp_rx_valid
);
  localparam int unsigned CW = $clog2(PCM_W + 1);
  localparam logic [CW-1:0] LEN_WORD = CW'(PCM_W);
  localparam logic [CW-1:0] LEN_CODE = CW'(ADP_W);

  // Control inputs brought into each domain.
  logic [1:0] ctl_p, ctl_a;
  logic thru_p, en_p, thru_a, en_a;

  vp_sync2 #(.W(2)) u_ctl_p (.clk(pcm_bclk), .rst(rst), .d({passthru, chan_en}), .q(ctl_p));
  vp_sync2 #(.W(2)) u_ctl_a (.clk(adp_bclk), .rst(rst), .d({passthru, chan_en}), .q(ctl_a));

  assign {thru_p, en_p} = ctl_p;
  assign {thru_a, en_a} = ctl_a;

  // Crossing words.
  logic [PCM_W-1:0] p2a_word, a2p_word, adp_word;
  logic             pcm_done, adp_done;

  vp_word_cdc #(.W(PCM_W)) u_p2a (
    .src_clk(pcm_bclk), .dst_clk(adp_bclk), .rst(rst),
    .load(pcm_done && thru_p), .din(pcm_rx_sample), .dout(p2a_word));

  vp_word_cdc #(.W(PCM_W)) u_a2p (
    .src_clk(adp_bclk), .dst_clk(pcm_bclk), .rst(rst),
    .load(adp_done && thru_a), .din(adp_word), .dout(a2p_word));

  // PCM side.
  logic [PCM_W-1:0] pcm_src;
  assign pcm_src = thru_p ? a2p_word : pcm_tx_sample;

  vp_ser_tx #(.MAXW(PCM_W)) u_pcm_tx (
    .clk(pcm_bclk), .rst(rst), .en(en_p), .start(pcm_sync_tx),
    .len(LEN_WORD), .word(pcm_src), .sdo(pcm_sdo), .oe(pcm_sdo_en));

  vp_ser_rx #(.MAXW(PCM_W)) u_pcm_rx (
    .clk(pcm_bclk), .rst(rst), .en(en_p), .report(!thru_p), .start(pcm_sync_rx),
    .len(LEN_WORD), .sdi(pcm_sdi), .word(pcm_rx_sample), .done(pcm_done),
    .valid(pcm_rx_valid));

  // ADPCM side: code is MSB aligned in the shift word.
  logic [PCM_W-1:0] adp_src;
  logic [CW-1:0]    adp_len;
  assign adp_src = thru_a ? p2a_word : {adp_tx_code, {(PCM_W-ADP_W){1'b0}}};
  assign adp_len = thru_a ? LEN_WORD : LEN_CODE;

  vp_ser_tx #(.MAXW(PCM_W)) u_adp_tx (
    .clk(adp_bclk), .rst(rst), .en(en_a), .start(adp_sync_tx),
    .len(adp_len), .word(adp_src), .sdo(adp_sdo), .oe(adp_sdo_en));

  vp_ser_rx #(.MAXW(PCM_W)) u_adp_rx (
    .clk(adp_bclk), .rst(rst), .en(en_a), .report(!thru_a), .start(adp_sync_rx),
    .len(adp_len), .sdi(adp_sdi), .word(adp_word), .done(adp_done),
    .valid(adp_rx_valid));

  assign adp_rx_code = adp_word[ADP_W-1:0];

  // R9: powered-down channel keeps both lines released.
  a_r9_pcm_quiet: assert property (@(posedge pcm_bclk) disable iff (rst)
    !en_p |=> !pcm_sdo_en);
  a_r9_adp_quiet: assert property (@(posedge adp_bclk) disable iff (rst)
    !en_a |=> !adp_sdo_en);

  // R8: no samples reach the arithmetic core in pass-through mode.
  a_r8_pcm_silent: assert property (@(posedge pcm_bclk) disable iff (rst)
    (thru_p && $past(thru_p)) |-> !pcm_rx_valid);
  a_r8_adp_silent: assert property (@(posedge adp_bclk) disable iff (rst)
    (thru_a && $past(thru_a)) |-> !adp_rx_valid);
endmodule

// File: tb/tb_voice_port.sv
module tb_voice_port;
  localparam int PCM_PERIOD = 10;
  localparam int ADP_PERIOD = 26;

  logic rst = 1'b1, chan_en = 1'b0, passthru = 1'b0;
  logic pcm_bclk = 1'b0, adp_bclk = 1'b0;
  logic pcm_sync_tx = 0, pcm_sync_rx = 0, pcm_sdi = 0;
  logic adp_sync_tx = 0, adp_sync_rx = 0, adp_sdi = 0;
  logic [7:0] pcm_tx_sample = '0;
  logic [3:0] adp_tx_code = '0;
  logic pcm_sdo, pcm_sdo_en, pcm_rx_valid, adp_sdo, adp_sdo_en, adp_rx_valid;
  logic [7:0] pcm_rx_sample;
  logic [3:0] adp_rx_code;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(PCM_PERIOD/2) pcm_bclk = ~pcm_bclk;
  always #(ADP_PERIOD/2) adp_bclk = ~adp_bclk;

  voice_port dut (
    .rst(rst), .chan_en(chan_en), .passthru(passthru),
    .pcm_bclk(pcm_bclk), .pcm_sync_tx(pcm_sync_tx), .pcm_sync_rx(pcm_sync_rx),
    .pcm_sdi(pcm_sdi), .pcm_sdo(pcm_sdo), .pcm_sdo_en(pcm_sdo_en),
    .pcm_tx_sample(pcm_tx_sample), .pcm_rx_sample(pcm_rx_sample), .pcm_rx_valid(pcm_rx_valid),
    .adp_bclk(adp_bclk), .adp_sync_tx(adp_sync_tx), .adp_sync_rx(adp_sync_rx),
    .adp_sdi(adp_sdi), .adp_sdo(adp_sdo), .adp_sdo_en(adp_sdo_en),
    .adp_tx_code(adp_tx_code), .adp_rx_code(adp_rx_code), .adp_rx_valid(adp_rx_valid));

  // Expected values from the requirements.
  function automatic logic [7:0] exp_pcm_out(bit thru, logic [7:0] sample, logic [7:0] xfer);
    return thru ? xfer : sample;
  endfunction

  function automatic logic [7:0] exp_adp_out(bit thru, logic [3:0] code, logic [7:0] xfer);
    return thru ? xfer : {4'b0, code};
  endfunction

  function automatic int exp_adp_len(bit thru);
    return thru ? 8 : 4;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick(input bit adp);
    if (adp) @(posedge adp_bclk);
    else     @(posedge pcm_bclk);
  endtask

  task automatic set_rx(input bit adp, input logic sync, input logic d);
    if (adp) begin adp_sync_rx = sync; adp_sdi = d; end
    else     begin pcm_sync_rx = sync; pcm_sdi = d; end
  endtask

  task automatic set_tx(input bit adp, input logic sync);
    if (adp) adp_sync_tx = sync;
    else     pcm_sync_tx = sync;
  endtask

  // Drive one receive frame, return the parallel result and valid.
  task automatic send(input bit adp, input int len, input logic [7:0] w,
                      output logic [7:0] got, output logic v);
    tick(adp); #1 set_rx(adp, 1'b1, 1'b0);
    tick(adp); #1 set_rx(adp, 1'b0, w[len-1]);
    for (int i = len - 2; i >= 0; i--) begin
      tick(adp); #1 set_rx(adp, 1'b0, w[i]);
    end
    tick(adp); #1;
    got = adp ? {4'b0, adp_rx_code} : pcm_rx_sample;
    v   = adp ? adp_rx_valid : pcm_rx_valid;
    set_rx(adp, 1'b0, 1'b0);
  endtask

  // Request one transmit frame and collect the line.
  task automatic recv(input bit adp, input int len, output logic [7:0] w,
                      output int hits, output logic tail);
    tick(adp); #1 set_tx(adp, 1'b1);
    tick(adp); #1 set_tx(adp, 1'b0);
    w = '0; hits = 0;
    for (int i = 0; i < len; i++) begin
      tick(adp); #2;
      w = {w[6:0], adp ? adp_sdo : pcm_sdo};
      hits += int'(adp ? adp_sdo_en : pcm_sdo_en);
    end
    tick(adp); #2;
    tail = adp ? adp_sdo_en : pcm_sdo_en;
  endtask

  task automatic idle(input bit adp, input int n);
    repeat (n) tick(adp);
  endtask

  task automatic pcm_out_case(input logic [7:0] s);
    logic [7:0] w; int h; logic t;
    pcm_tx_sample = s;
    recv(1'b0, 8, w, h, t);
    chk("R1 pcm word", w, exp_pcm_out(0, s, 8'h00));
    chk("R1 pcm enabled bits", h, 8);
    chk("R1 pcm release", t, 0);
  endtask

  initial begin
    logic [7:0] w, got; int h; logic t, v;
    void'($urandom(32'd2024));
    idle(1, 6);
    @(posedge pcm_bclk); #1 rst = 1'b0;
    #1;
    chk("R10 pcm_sdo_en", pcm_sdo_en, 0);
    chk("R10 adp_sdo_en", adp_sdo_en, 0);
    chk("R10 pcm_rx_valid", pcm_rx_valid, 0);
    chk("R10 adp_rx_valid", adp_rx_valid, 0);
    chk("R10 pcm_rx_sample", pcm_rx_sample, 0);

    chan_en = 1'b1;
    idle(1, 5);

    // Directed corner patterns on the PCM output.
    pcm_out_case(8'h80);
    pcm_out_case(8'h01);
    pcm_out_case(8'hFF);
    pcm_out_case(8'h00);

    // Randomised normal-mode traffic.
    for (int k = 0; k < 20; k++) begin
      pcm_out_case(8'($urandom));
      w = 8'($urandom);
      send(1'b0, 8, w, got, v);
      chk("R4 pcm sample", got, w);
      chk("R4 pcm valid", v, 1);
      tick(0); #1;
      chk("R4 pcm valid one cycle", pcm_rx_valid, 0);
      adp_tx_code = 4'($urandom);
      recv(1'b1, exp_adp_len(0), w, h, t);
      chk("R2 adp code", w, exp_adp_out(0, adp_tx_code, 8'h00));
      chk("R2 adp enabled bits", h, 4);
      chk("R2 adp release", t, 0);
      w = {4'b0, 4'($urandom)};
      send(1'b1, 4, w, got, v);
      chk("R5 adp code in", got, w);
      chk("R5 adp valid", v, 1);
    end

    // Pass-through mode.
    passthru = 1'b1;
    idle(1, 5);
    for (int k = 0; k < 12; k++) begin
      w = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
      send(1'b0, 8, w, got, v);
      chk("R8 pcm valid held low", v, 0);
      idle(1, 12);
      recv(1'b1, exp_adp_len(1), got, h, t);
      chk("R6 pcm to adp word", got, exp_adp_out(1, 4'h0, w));
      chk("R3 adp enabled bits", h, 8);
      chk("R3 adp release", t, 0);
      recv(1'b1, 8, got, h, t);
      chk("R11 repeated word", got, w);
      w = (k == 0) ? 8'hFF : (k == 1) ? 8'h00 : 8'($urandom);
      send(1'b1, 8, w, got, v);
      chk("R8 adp valid held low", v, 0);
      idle(0, 12);
      pcm_tx_sample = ~w;
      recv(1'b0, 8, got, h, t);
      chk("R7 adp to pcm word", got, exp_pcm_out(1, pcm_tx_sample, w));
      chk("R7 pcm enabled bits", h, 8);
    end
    passthru = 1'b0;
    idle(1, 5);

    // Power down.
    chan_en = 1'b0;
    idle(1, 5);
    pcm_tx_sample = 8'hA5;
    recv(1'b0, 8, got, h, t);
    chk("R9 pcm line quiet", h, 0);
    recv(1'b1, 4, got, h, t);
    chk("R9 adp line quiet", h, 0);
    send(1'b0, 8, 8'h3C, got, v);
    chk("R9 pcm valid quiet", v, 0);
    send(1'b1, 4, 8'h09, got, v);
    chk("R9 adp valid quiet", v, 0);
    chan_en = 1'b1;
    idle(1, 5);
    pcm_out_case(8'h5A);
    send(1'b0, 8, 8'hC3, got, v);
    chk("R9 resume pcm sample", got, 8'hC3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge pcm_bclk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule